// File: doc/BRIEF.md
# Multiplexed Bus Fetch Snooper

This block watches, without driving anything, the external program-memory bus of a small 8-bit controller. On that bus one byte-wide set of lines carries first the low half of the fetch address and then the fetched byte. Four further lines carry address bits 11..8. The block samples every bus line with its own fast clock through a two-stage synchronizer. It finds strobe edges by comparing each synchronized sample with the one before it.

A falling address strobe stores the fetch address. A rising program-store strobe (the strobe is active low) takes the byte on the shared lines as the fetched data. It then offers one 24-bit record on a valid/ready output. A static configuration input can add a thirteenth address bit, taken from a separate line. Records are only produced after the first address has been stored since reset.

The output register holds one record. While `rec_valid` is high and `rec_ready` is low, the record and its valid stay frozen. A record that is produced in that state is discarded, and `overflow` goes high and stays high until reset. A record that arrives in the same cycle as a handshake replaces the one being accepted.

Top module: `fetch_snoop`

## Requirements
- R1: While `rst` is high at a clock edge, `rec_valid` and `overflow` are low after that edge.
- R2: A falling edge on `ale` stores the address with bits 7..0 taken from `bus_ad` and bits 11..8 from `addr_hi`. Bits 15..13 are always zero.
- R3: With `bank_en` high, address bit 12 is the value of `bank_bit` at the `ale` fall. With `bank_en` low, bit 12 is zero.
- R4: A rising edge on `psen_n` produces a record `rec_data` = {address[15:8], address[7:0], byte}. The byte is `bus_ad` at that edge, and the record appears at most 4 clocks after the edge reaches the pins.
- R5: A rising edge on `psen_n` before any `ale` fall since reset produces no record.
- R6: When an `ale` fall and a `psen_n` rise land in the same sample, the record carries the address stored by that same `ale` fall.
- R7: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` stays unchanged.
- R8: A record produced while an unaccepted record is pending is dropped. It sets `overflow`, which then stays high until reset.
- R9: A handshake (`rec_valid` and `rec_ready` both high) with no new record clears `rec_valid` on the next clock.
- R10: A rising `ale` or a falling `psen_n` produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_en | input | 1 | Static: use `bank_bit` as address bit 12 |
| bus_ad | input | 8 | Shared low-address / data lines |
| addr_hi | input | 4 | Address bits 11..8 |
| bank_bit | input | 1 | Optional address bit 12 |
| ale | input | 1 | Address strobe; its falling edge stores the address |
| psen_n | input | 1 | Program-store strobe, active low; its rising edge captures data |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_data | output | 24 | Address high, address low, data byte |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
A stored address that is wrong, or that is stored on the wrong strobe edge, shows up in bits 23..8 of the very next record. That record appears within four clocks of the `psen_n` rise. A stale or missing started flag shows as a record that appears, or fails to appear, right after the first strobe following reset. An output register that mishandles back-pressure shows either as a changed `rec_data` while the output is stalled, or as `overflow` staying low after a second record arrives without a handshake.

// File: rtl/fsnp_pkg.sv
package fsnp_pkg;
  localparam int DATA_W = 8;
  localparam int HI_W   = 4;
  localparam int ADDR_W = 16;
  localparam int REC_W  = ADDR_W + DATA_W;

  function automatic logic [REC_W-1:0] make_rec(input logic [ADDR_W-1:0] a,
                                                input logic [DATA_W-1:0] d);
    return {a, d};
  endfunction
endpackage

// File: rtl/fsnp_sync.sv
module fsnp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/fsnp_addr_latch.sv
module fsnp_addr_latch
  import fsnp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_fall,
  input  logic              bank_en,
  input  logic [DATA_W-1:0] lo,
  input  logic [HI_W-1:0]   hi,
  input  logic              bank,
  output logic [ADDR_W-1:0] addr_eff,
  output logic              started_eff
);
  localparam int PAD_W = ADDR_W - DATA_W - HI_W - 1;

  logic [ADDR_W-1:0] addr_q, addr_new;
  logic              started_q;

  // Address store comes first, so a same-sample capture sees the new value.
  assign addr_new    = {{PAD_W{1'b0}}, bank & bank_en, hi, lo};
  assign addr_eff    = ale_fall ? addr_new : addr_q;
  assign started_eff = started_q | ale_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      started_q <= 1'b0;
    end else if (ale_fall) begin
      addr_q    <= addr_new;
      started_q <= 1'b1;
    end
  end

  // R5
  started_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    started_q |=> started_q);
  // R2
  addr_pad_chk: assert property (@(posedge clk) disable iff (rst)
    addr_q[ADDR_W-1:ADDR_W-PAD_W] == '0);
endmodule

// File: rtl/fsnp_rec_out.sv
module fsnp_rec_out
  import fsnp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [REC_W-1:0] rec_in,
  input  logic             ready,
  output logic             valid,
  output logic [REC_W-1:0] data,
  output logic             ovf
);
  logic             valid_q, ovf_q;
  logic [REC_W-1:0] data_q;
  logic             stall;

  assign stall = valid_q & ~ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (push && stall) begin
        ovf_q <= 1'b1;
      end else if (push) begin
        valid_q <= 1'b1;
        data_q  <= rec_in;
      end else if (valid_q && ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign ovf   = ovf_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid && !ovf));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && push) |=> ovf);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R9
  accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && !push) |=> !valid);
endmodule

// File: rtl/fetch_snoop.sv
module fetch_snoop
  import fsnp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_en,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              bank_bit,
  input  logic              ale,
  input  logic              psen_n,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [REC_W-1:0]  rec_data,
  output logic              overflow
);
  localparam int SW = DATA_W + HI_W + 3;
  localparam int P_ALE  = DATA_W + HI_W;
  localparam int P_PSEN = P_ALE + 1;
  localparam int P_BANK = P_ALE + 2;

  logic [SW-1:0]     s_cur, s_prv;
  logic              ale_fall, psen_rise, started, push;
  logic [ADDR_W-1:0] addr_eff;
  logic [REC_W-1:0]  rec_new;

  fsnp_sync #(.W(SW)) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({bank_bit, psen_n, ale, addr_hi, bus_ad}),
    .cur (s_cur),
    .prv (s_prv)
  );

  assign ale_fall  = s_prv[P_ALE] & ~s_cur[P_ALE];
  assign psen_rise = ~s_prv[P_PSEN] & s_cur[P_PSEN];

  fsnp_addr_latch alat_i (
    .clk         (clk),
    .rst         (rst),
    .ale_fall    (ale_fall),
    .bank_en     (bank_en),
    .lo          (s_cur[DATA_W-1:0]),
    .hi          (s_cur[P_ALE-1:DATA_W]),
    .bank        (s_cur[P_BANK]),
    .addr_eff    (addr_eff),
    .started_eff (started)
  );

  assign push    = psen_rise & started;
  assign rec_new = make_rec(addr_eff, s_cur[DATA_W-1:0]);

  fsnp_rec_out rout_i (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .rec_in (rec_new),
    .ready  (rec_ready),
    .valid  (rec_valid),
    .data   (rec_data),
    .ovf    (overflow)
  );

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!psen_rise && !(rec_valid && !rec_ready)) |=> !(rec_valid && !$past(rec_valid)));
  // R3
  bank_off_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !bank_en) |-> (rec_new[DATA_W+12] == 1'b0));
endmodule

// File: tb/fetch_snoop_tb_top.sv
module fetch_snoop_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_en = 1'b0;
  logic [7:0]  bus_ad = '0;
  logic [3:0]  addr_hi = '0;
  logic        bank_bit = 1'b0;
  logic        ale = 1'b0;
  logic        psen_n = 1'b1;
  logic        rec_ready = 1'b0;
  logic        rec_valid, overflow;
  logic [23:0] rec_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_snoop dut_i (
    .clk(clk), .rst(rst), .bank_en(bank_en), .bus_ad(bus_ad),
    .addr_hi(addr_hi), .bank_bit(bank_bit), .ale(ale), .psen_n(psen_n),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .overflow(overflow)
  );

  function automatic logic [23:0] exp_rec(input logic [3:0] hi, input logic [7:0] lo,
                                          input logic en, input logic b,
                                          input logic [7:0] d);
    return {3'b000, en & b, hi, lo, d};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_addr(input logic [3:0] hi, input logic [7:0] lo, input logic b);
    ale = 1'b1; bus_ad = lo; addr_hi = hi; bank_bit = b;
    cyc(4);
    ale = 1'b0;
    cyc(4);
  endtask

  task automatic put_data(input logic [7:0] d);
    bus_ad = d;
    psen_n = 1'b0;
    cyc(4);
    psen_n = 1'b1;
    cyc(4);
  endtask

  task automatic accept();
    rec_ready = 1'b1;
    cyc(1);
    rec_ready = 1'b0;
  endtask

  initial begin
    cyc(1000000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cyc(4);
    chk("R1 valid after reset", rec_valid, 0);
    chk("R1 overflow after reset", overflow, 0);
    rst = 1'b0;
    cyc(2);

    // R5: capture strobe before any address strobe
    put_data(8'h3c);
    chk("R5 no record before first ale", rec_valid, 0);

    // R2/R4 directed, then R10 checks after address phase
    put_addr(4'hA, 8'h55, 1'b1);
    chk("R10 no record from ale edges", rec_valid, 0);
    bus_ad = 8'hC3; psen_n = 1'b0; cyc(4);
    chk("R10 no record on psen fall", rec_valid, 0);
    psen_n = 1'b1; cyc(5);
    chk("R4 record valid", rec_valid, 1);
    chk("R2 R4 record content (bank off)", rec_data, exp_rec(4'hA, 8'h55, 1'b0, 1'b1, 8'hC3));
    cyc(3);
    chk("R7 held while stalled", rec_data, exp_rec(4'hA, 8'h55, 1'b0, 1'b1, 8'hC3));
    accept();
    chk("R9 cleared after handshake", rec_valid, 0);

    // Random fetches, bank enable varied
    for (int i = 0; i < 60; i++) begin
      logic [3:0] hi = 4'($urandom);
      logic [7:0] lo = 8'($urandom);
      logic [7:0] d  = 8'($urandom);
      logic       b  = 1'($urandom);
      logic       en = 1'($urandom);
      bank_en = en;
      put_addr(hi, lo, b);
      put_data(d);
      cyc(1);
      chk("R4 random record valid", rec_valid, 1);
      chk("R2 R3 R4 random record", rec_data, exp_rec(hi, lo, en, b, d));
      accept();
      chk("R9 random clear", rec_valid, 0);
    end

    // R3 directed: bank bit enabled
    bank_en = 1'b1;
    put_addr(4'h0, 8'h00, 1'b1);
    put_data(8'hFF);
    chk("R3 bank bit set", rec_data, 24'h1000FF);
    accept();

    // R6: address strobe fall and capture strobe rise in the same sample
    bank_en = 1'b0;
    ale = 1'b1; psen_n = 1'b0; addr_hi = 4'h7; bus_ad = 8'h11;
    cyc(4);
    bus_ad = 8'h9E; ale = 1'b0; psen_n = 1'b1;
    cyc(5);
    chk("R6 same-sample uses new address", rec_data, 24'h079E9E);
    accept();

    // R8: second record while first pending
    put_addr(4'h2, 8'h20, 1'b0);
    put_data(8'h01);
    chk("R8 overflow low before drop", overflow, 0);
    put_addr(4'h3, 8'h30, 1'b0);
    put_data(8'h02);
    chk("R8 first record kept", rec_data, 24'h022001);
    chk("R8 overflow set", overflow, 1);
    accept();
    put_addr(4'h4, 8'h40, 1'b0);
    put_data(8'h03);
    chk("R8 next record ok", rec_data, 24'h044003);
    chk("R8 overflow sticky", overflow, 1);
    accept();

    // R1: reset clears overflow and started state
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(2);
    chk("R1 overflow cleared", overflow, 0);
    put_data(8'h44);
    chk("R5 no record after reset before ale", rec_valid, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule